// File: doc/BRIEF.md
# Shadow-Loaded Quad PWM Generator

This block produces four independent pulse-width modulated outputs from a single input clock. Each channel is programmed through a 32-bit word-addressed register interface with a waveform length (the period, in clock cycles) and a count of low cycles inside that period. The high part of each period comes first, and the low part fills the remainder. Shared control words hold one bit per channel for run, reload, inversion, pin direction and completion status.

Programmed values never drive the counters directly. When a channel is started, a private working copy of its period and low count is taken, and the counter begins at zero. Software can then rewrite the programmed values at any time without disturbing the running waveform. The new values are adopted only after software writes 1 and then 0 to the channel's reload bit. Even then they take effect at the next period boundary, so every period is produced whole with one consistent set of values.

The bus is a plain strobe interface. Read data is combinational from the address. A write is taken on the clock edge where the write strobe is high. A read of the status word clears it on the clock edge where the read strobe is high.

Top module: `pwm_quad_shadow`

## Requirements
- R1: After reset, every period register reads 2, every low-count register reads 1, the polarity, run, reload, status and direction words read 0, and pwm_out and pwm_oe are 0.
- R2: Channel n's low count is at byte offset 8*n and its period at 8*n+4, and both hold 30 bits (bits 31:30 read 0). Bit n of the shared words controls channel n: inversion at 0x40, run at 0x44, status at 0x48, reload at 0x4C and pin direction at 0xD0. Any other offset, and any write to 0x48, reads 0 and changes nothing.
- R3: A period write of 0 or 1 is stored as 2, and any other value is stored as written.
- R4: A running channel counts 0 to P-1 repeatedly, where P is its working period and L its working low count. Its output is high while the count is below P-L and low otherwise. L=0 gives a constant high output, and L>=P gives a constant low output.
- R5: Writing a run bit from 0 to 1 copies that channel's programmed period and low count into its working copy. On the following cycle the count is 0.
- R6: While a channel runs, writes to its period and low-count registers do not change its output.
- R7: A reload is requested by a write that clears a reload bit that reads 1. The working copy reloads on the clock edge where the count wraps from P-1 to 0, so the period already in progress completes with the old values.
- R8: A channel whose run bit is 0 drives pwm_out low, whatever its inversion bit.
- R9: Setting a channel's inversion bit inverts its output while it runs.
- R10: pwm_oe[n] equals bit n of the direction word (1 means the pin is driven as an output).
- R11: Status bit n is set when channel n stops or when a reload is applied. A read of 0x48 clears it, but a set in the same cycle as the read takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the status word when it addresses it) |
| bus_addr | input | 8 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 4 | Waveform outputs, one per channel |
| pwm_oe | output | 4 | Pin direction per channel, 1 = drive |

## Verification
Every cycle, the assertions check that a stopped channel's pin is low, that the count stays below the working period, and that the working copy holds still between period boundaries. They also check that the count is zero after a start or a wrap, that a stored period is never below 2, and that a status read clears the word. Only the bench scenarios can show the real waveform shapes: the duty rule, the two duty extremes, inversion, and the old period finishing before a reload is adopted. The same applies to the restart latching fresh values and the address map. Each of these is checked cycle by cycle against an expected queue.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
   localparam int BUS_AW     = 8;
   localparam int MAX_CH     = 8;
   localparam int PERIOD_MIN = 2;
   localparam int PERIOD_RST = 2;
   localparam int LOW_RST    = 1;

   localparam logic [BUS_AW-1:0] OFS_INV  = 8'h40;
   localparam logic [BUS_AW-1:0] OFS_RUN  = 8'h44;
   localparam logic [BUS_AW-1:0] OFS_STAT = 8'h48;
   localparam logic [BUS_AW-1:0] OFS_RLD  = 8'h4C;
   localparam logic [BUS_AW-1:0] OFS_DIR  = 8'hD0;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
   import pwm_quad_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 30,
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [BUS_AW-1:0]             bus_addr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]  prog_period,
   output logic [NUM_CH-1:0][CNT_W-1:0]  prog_low,
   output logic [NUM_CH-1:0]             run_q,
   output logic [NUM_CH-1:0]             inv_q,
   output logic [NUM_CH-1:0]             dir_q,
   output logic [NUM_CH-1:0]             start_load,
   output logic [NUM_CH-1:0]             reload_arm,
   input  logic [NUM_CH-1:0]             reload_done
);
   localparam int IDX_W = 3;

   logic              word_ok;
   logic              in_chan_win;
   logic [IDX_W-1:0]  ch_idx;
   logic [NUM_CH-1:0] wbits;
   logic [NUM_CH-1:0] rld_q;
   logic [NUM_CH-1:0] stat_q;
   logic [NUM_CH-1:0] stat_set;
   logic              stat_clr;
   logic              wr_run, wr_rld;

   assign word_ok     = (bus_addr[1:0] == 2'b00);
   assign in_chan_win = word_ok && (bus_addr[7:6] == 2'b00);
   assign ch_idx      = bus_addr[5:3];
   assign wbits       = bus_wdata[NUM_CH-1:0];
   assign wr_run      = bus_wr && (bus_addr == OFS_RUN);
   assign wr_rld      = bus_wr && (bus_addr == OFS_RLD);

   if (CNT_W < DATA_W) begin : g_wsink
      logic unused_wbits;
      assign unused_wbits = ^bus_wdata[DATA_W-1:CNT_W];
   end

   // per-channel programmed values
   for (genvar n = 0; n < NUM_CH; n++) begin : g_prog
      logic             sel_low, sel_per;
      logic [CNT_W-1:0] low_r, per_r, per_in;

      assign sel_low = bus_wr && in_chan_win && (ch_idx == IDX_W'(n)) && !bus_addr[2];
      assign sel_per = bus_wr && in_chan_win && (ch_idx == IDX_W'(n)) &&  bus_addr[2];
      assign per_in  = (bus_wdata[CNT_W-1:0] < CNT_W'(PERIOD_MIN)) ?
                       CNT_W'(PERIOD_MIN) : bus_wdata[CNT_W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            low_r <= CNT_W'(LOW_RST);
            per_r <= CNT_W'(PERIOD_RST);
         end else begin
            if (sel_low) low_r <= bus_wdata[CNT_W-1:0];
            if (sel_per) per_r <= per_in;
         end
      end

      assign prog_low[n]    = low_r;
      assign prog_period[n] = per_r;

      AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
         per_r >= CNT_W'(PERIOD_MIN)); // R3
   end

   // shared control words
   assign start_load = wr_run ? (wbits & ~run_q) : '0;
   assign reload_arm = wr_rld ? (rld_q & ~wbits) : '0;
   assign stat_set   = reload_done | (wr_run ? (run_q & ~wbits) : '0);
   assign stat_clr   = bus_rd && (bus_addr == OFS_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         inv_q  <= '0;
         dir_q  <= '0;
         rld_q  <= '0;
         stat_q <= '0;
      end else begin
         if (wr_run) run_q <= wbits;
         if (wr_rld) rld_q <= wbits;
         if (bus_wr && bus_addr == OFS_INV) inv_q <= wbits;
         if (bus_wr && bus_addr == OFS_DIR) dir_q <= wbits;
         stat_q <= (stat_clr ? '0 : stat_q) | stat_set;
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         if (in_chan_win && ch_idx == IDX_W'(n))
            bus_rdata = bus_addr[2] ? DATA_W'(prog_period[n]) : DATA_W'(prog_low[n]);
      end
      case (bus_addr)
         OFS_INV:  bus_rdata = DATA_W'(inv_q);
         OFS_RUN:  bus_rdata = DATA_W'(run_q);
         OFS_STAT: bus_rdata = DATA_W'(stat_q);
         OFS_RLD:  bus_rdata = DATA_W'(rld_q);
         OFS_DIR:  bus_rdata = DATA_W'(dir_q);
         default:  ;
      endcase
   end

   AST_STAT_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && stat_set == '0) |=> (stat_q == '0)); // R11
   AST_ARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_arm != '0) |=> ((rld_q & $past(reload_arm)) == '0)); // R7
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
   import pwm_quad_pkg::*;
#(
   parameter int CNT_W   = 30,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             start_load,
   input  logic             reload_arm,
   input  logic             invert,
   input  logic [CNT_W-1:0] prog_period,
   input  logic [CNT_W-1:0] prog_low,
   output logic             wave,
   output logic             reload_done
);
   logic [CNT_W-1:0] cnt_q, wp_q, wl_q, hi_len;
   logic             pend_q, wrap, do_reload, wave_c;

   assign wrap        = (cnt_q == wp_q - CNT_W'(1));
   assign hi_len      = (wl_q >= wp_q) ? '0 : (wp_q - wl_q);
   assign do_reload   = run && wrap && (pend_q || reload_arm);
   assign reload_done = do_reload && !start_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wp_q   <= CNT_W'(PERIOD_RST);
         wl_q   <= CNT_W'(LOW_RST);
         pend_q <= 1'b0;
      end else if (start_load) begin
         cnt_q  <= '0;
         wp_q   <= prog_period;
         wl_q   <= prog_low;
         pend_q <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         if (do_reload) begin
            wp_q <= prog_period;
            wl_q <= prog_low;
         end
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (reload_arm) pend_q <= 1'b1;
      end
   end

   assign wave_c = run & ((cnt_q < hi_len) ^ invert);

   if (REG_OUT) begin : g_flop_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wave <= 1'b0;
         else        wave <= wave_c;
      end
   end else begin : g_comb_out
      assign wave = wave_c;
   end

   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < wp_q)); // R4
   AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start_load |=> (cnt_q == '0)); // R5
   AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start_load && !wrap) |=> ($stable(wp_q) && $stable(wl_q))); // R6
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wrap && !start_load) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/pwm_quad_shadow.sv
module pwm_quad_shadow
   import pwm_quad_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int CNT_W   = 30,
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out,
   output logic [NUM_CH-1:0] pwm_oe
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie in 1..8");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < MAX_CH) begin : g_bad_data
      $error("DATA_W too narrow for control words");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] prog_period, prog_low;
   logic [NUM_CH-1:0]            run_q, inv_q, dir_q;
   logic [NUM_CH-1:0]            start_load, reload_arm, reload_done;

   pwm_quad_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .prog_period(prog_period), .prog_low(prog_low),
      .run_q(run_q), .inv_q(inv_q), .dir_q(dir_q),
      .start_load(start_load), .reload_arm(reload_arm),
      .reload_done(reload_done)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      pwm_chan_core #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) core_i (
         .clk(clk), .rst_n(rst_n),
         .run(run_q[n]), .start_load(start_load[n]),
         .reload_arm(reload_arm[n]), .invert(inv_q[n]),
         .prog_period(prog_period[n]), .prog_low(prog_low[n]),
         .wave(pwm_out[n]), .reload_done(reload_done[n])
      );

      if (REG_OUT) begin : g_chk_flop
         AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !run_q[n] |=> !pwm_out[n]); // R8
      end else begin : g_chk_comb
         AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !run_q[n] |-> !pwm_out[n]); // R8
      end
   end

   assign pwm_oe = dir_q;
endmodule

// File: tb/pwm_quad_shadow_tb_top.sv
module pwm_quad_shadow_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out, pwm_oe;

   int n_chk = 0, n_fail = 0;

   typedef struct { int ch; logic v; string tag; } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   pwm_quad_shadow dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push(input int ch, input logic v, input string tag);
      exp_t e;
      e.ch = ch; e.v = v; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: pops one expected sample per cycle, after the edge settles
   initial forever begin
      @(posedge clk); #2;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_chk++;
         if (pwm_out[e.ch] !== e.v) begin
            n_fail++;
            $display("FAIL %s pwm_out[%0d] actual %b expected %b", e.tag, e.ch, pwm_out[e.ch], e.v);
         end
      end
   end

   task automatic drain();
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int n = 0; n < 4; n++) begin
         rd_chk("R1 low count reset", 8'(8*n), 32'd1);
         rd_chk("R1 period reset", 8'(8*n+4), 32'd2);
      end
      rd_chk("R1 inversion", 8'h40, 0);
      rd_chk("R1 run", 8'h44, 0);
      rd_chk("R1 status", 8'h48, 0);
      rd_chk("R1 reload", 8'h4C, 0);
      rd_chk("R1 direction", 8'hD0, 0);
      chk("R1 pwm_out", 32'(pwm_out), 0);
      chk("R1 pwm_oe", 32'(pwm_oe), 0);

      // R2 / R3 map, width and clamp
      wr(8'h1C, 32'd1);
      rd_chk("R3 period clamp 1", 8'h1C, 32'd2);
      wr(8'h1C, 32'd0);
      rd_chk("R3 period clamp 0", 8'h1C, 32'd2);
      wr(8'h1C, 32'hC000_0007);
      rd_chk("R2 period 30 bit", 8'h1C, 32'd7);
      wr(8'h80, 32'hFFFF_FFFF);
      rd_chk("R2 unmapped read", 8'h80, 0);
      rd_chk("R2 unmapped no alias", 8'h00, 32'd1);
      wr(8'h48, 32'hF);
      rd_chk("R2 status write ignored", 8'h48, 0);

      // R10 direction
      wr(8'hD0, 32'hA);
      chk("R10 pwm_oe", 32'(pwm_oe), 32'hA);
      rd_chk("R10 direction readback", 8'hD0, 32'hA);

      // R4 + R6: start ch0 P=5 L=2, then rewrite while running
      wr(8'h04, 32'd5);
      wr(8'h00, 32'd2);
      wr(8'h44, 32'h1);
      wr(8'h04, 32'd4);
      wr(8'h00, 32'd1);
      for (int k = 3; k <= 12; k++) push(0, (k % 5) < 3, "R6 running waveform unchanged");
      drain();

      // R7: arm reload right after a rise (count 0)
      prev = pwm_out[0];
      forever begin
         @(negedge clk);
         if (pwm_out[0] && !prev) break;
         prev = pwm_out[0];
      end
      wr(8'h4C, 32'h1);
      wr(8'h4C, 32'h0);
      push(0, 1'b0, "R7 old period completes");
      push(0, 1'b0, "R7 old period completes");
      for (int k = 0; k < 8; k++) push(0, (k % 4) < 3, "R7 new values after boundary");
      drain();
      rd_chk("R11 status after reload", 8'h48, 32'h1);
      rd_chk("R11 status cleared by read", 8'h48, 0);

      // R8 stop
      wr(8'h44, 32'h0);
      for (int k = 0; k < 3; k++) push(0, 1'b0, "R8 stopped low");
      drain();
      rd_chk("R11 status after stop", 8'h48, 32'h1);

      // R9 inversion on ch1 P=4 L=1
      wr(8'h0C, 32'd4);
      wr(8'h08, 32'd1);
      wr(8'h40, 32'h2);
      wr(8'h44, 32'h2);
      for (int k = 1; k <= 8; k++) push(1, !((k % 4) < 3), "R9 inverted waveform");
      drain();
      wr(8'h44, 32'h0);
      for (int k = 0; k < 3; k++) push(1, 1'b0, "R8 stopped low despite inversion");
      drain();
      rd_chk("R11 status ch1 stop", 8'h48, 32'h2);

      // R4 extremes: ch2 L>=P, ch3 L=0
      wr(8'h14, 32'd3);
      wr(8'h10, 32'd7);
      wr(8'h18, 32'd0);
      wr(8'h44, 32'hC);
      for (int k = 0; k < 6; k++) begin
         push(2, 1'b0, "R4 low count above period");
         push(3, 1'b1, "R4 zero low count");
      end
      drain();
      wr(8'h44, 32'h0);

      // R5 restart latches fresh programmed values (P=6 L=3)
      wr(8'h04, 32'd6);
      wr(8'h00, 32'd3);
      wr(8'h44, 32'h1);
      for (int k = 1; k <= 8; k++) push(0, (k % 6) < 3, "R5 restart loads new values");
      drain();
      rd_chk("R2 run readback", 8'h44, 32'h1);

      finish_run();
   end
endmodule